// File: doc/BRIEF.md
# Oversampled Serial Pattern Receiver

This block watches an asynchronous serial line that has no clock of its own. It runs on a local receive clock set to four times the bit rate. While the line reads high, the block waits. A low level is treated as a possible start bit. The block accepts it only if the line is still low two clock cycles later. A low that does not last that long is treated as noise and ignored.

Once a start is accepted, the block samples the line once per bit period, at the clock cycle closest to the middle of each bit. Each sampled bit enters a four-bit window. The window is compared with a pattern that can be changed while the block is running. A match produces a one-cycle pulse, and matches that overlap each produce their own pulse. A separate one-cycle pulse marks the start of each stream. When the window fills with all ones, the block treats the stream as finished (or broken) and returns to waiting.

Top module: `rxs_pattern_rx`

## Requirements
- R1: Driving `clr_n` low forces `start_o` and `match_o` low at once, without waiting for a clock edge. The block is then idle with no bits received.
- R2: While `line_i` is sampled high in the idle state, `start_o` and `match_o` stay low.
- R3: Suppose the idle block samples `line_i` low at clock edge k and samples it high at edge k+2. No stream starts, and the block is idle again from edge k+2 onward.
- R4: If `line_i` is also low at edge k+2, a stream starts. `start_o` is high for exactly the one cycle after edge k+2, and the start bit itself does not enter the window.
- R5: Data bits are sampled at edges k+2+4n for n = 1, 2, … . The first bit received moves toward the most significant end, so after four bits the oldest bit sits in window bit 3 and the newest in bit 0.
- R6: `match_o` is high for exactly the one cycle after a sampling edge at which the updated window equals `pattern_i`. A match counts only when at least four data bits have been received since the latest start.
- R7: Overlapping occurrences each produce a pulse. With pattern 0110, the bits 0110110110 give three pulses.
- R8: When the updated window holds 1111, the block goes idle after that edge. A later low start bit begins a new stream with an empty window.
- R9: With `pattern_i` = 1111, the ending window produces one `match_o` pulse, and the block then goes idle.
- R10: `pattern_i` is read at each sampling edge, so changing it in the middle of a stream takes effect from the next sampled bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, four times the bit rate |
| clr_n | input | 1 | Asynchronous clear, active low |
| line_i | input | 1 | Serial line; high when idle; must already be synchronous to `clk` |
| pattern_i | input | 4 | Pattern to look for; bit 3 is the oldest received bit |
| start_o | output | 1 | One-cycle pulse when a start bit is confirmed |
| match_o | output | 1 | One-cycle pulse for each pattern match |

## Verification
The hardest case to reach from the ports is a window left over from an earlier stream that would match if it had not been cleared. The stimulus sets the pattern to 1110 and ends one stream on 1111. It then starts a new stream whose first data bit is 0. If the old window survived, those bits would form 1110 too early, so any stale state shows up as a spurious match. Glitches of one and two cycles probe both sides of the confirmation point. A clear in the middle of a bit probes the asynchronous path.

// File: rtl/rxs_pkg.sv
// Package: shared types for the oversampled pattern receiver.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable types.
package rxs_pkg;

    // Receiver control phases
    typedef enum logic [1:0] {
        RX_IDLE    = 2'd0,   // waiting for a low level on the line
        RX_CONFIRM = 2'd1,   // low seen, waiting to re-sample it
        RX_DATA    = 2'd2    // stream accepted, sampling once per bit
    } rx_state_t;

endpackage

// File: rtl/rxs_phase_ctr.sv
// Module: rxs_phase_ctr
// What: loadable down-counter that times both the start-confirmation delay
//       and the spacing between data samples; zero_o marks the due cycle.
// Assumes: load_val_i never exceeds CNT_MAX; counter rests at zero.
module rxs_phase_ctr #(
    parameter int OSR         = 4,
    parameter int CONFIRM_DLY = 2,
    localparam int CNT_MAX    = (OSR > CONFIRM_DLY) ? OSR - 1 : CONFIRM_DLY - 1,
    localparam int CW         = (CNT_MAX < 1) ? 1 : $clog2(CNT_MAX + 1)
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);

    logic [CW-1:0] cnt_q;

    // Purpose: reload on request, otherwise count down and rest at zero.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    AST_CTR_BOUND: assert property (@(posedge clk) disable iff (!clr_n)
        cnt_q <= CW'(CNT_MAX)); // R5

    AST_CTR_REST: assert property (@(posedge clk) disable iff (!clr_n)
        (zero_o && !load_i) |=> zero_o); // R5

endmodule

// File: rtl/rxs_ctrl.sv
// Module: rxs_ctrl
// What: control FSM. It confirms start bits, paces the sampling of data
//       bits, raises the start pulse and returns to idle on end of stream.
// Assumes: line_i is already synchronous to clk; stop_i is combinational
//          from the window and is acted on only at a sampling edge.
module rxs_ctrl
    import rxs_pkg::*;
#(
    parameter int OSR         = 4,
    parameter int CONFIRM_DLY = 2,
    localparam int CNT_MAX    = (OSR > CONFIRM_DLY) ? OSR - 1 : CONFIRM_DLY - 1,
    localparam int CW         = (CNT_MAX < 1) ? 1 : $clog2(CNT_MAX + 1)
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          line_i,
    input  logic          zero_i,
    input  logic          stop_i,
    output logic          load_o,
    output logic [CW-1:0] load_val_o,
    output logic          sample_o,
    output logic          flush_o,
    output logic          start_o
);

    rx_state_t state_q, state_d;
    logic      confirm;
    logic      start_q;

    // Purpose: next-state decisions and counter reload requests.
    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        load_val_o = CW'(CONFIRM_DLY - 1);
        confirm    = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                if (!line_i) begin
                    state_d = RX_CONFIRM;
                    load_o  = 1'b1;
                end
            end
            RX_CONFIRM: begin
                if (zero_i) begin
                    if (!line_i) begin
                        state_d    = RX_DATA;
                        load_o     = 1'b1;
                        load_val_o = CW'(OSR - 1);
                        confirm    = 1'b1;
                    end else begin
                        state_d = RX_IDLE;
                    end
                end
            end
            RX_DATA: begin
                if (zero_i) begin
                    load_o     = 1'b1;
                    load_val_o = CW'(OSR - 1);
                    if (stop_i) begin
                        state_d = RX_IDLE;
                    end
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // Purpose: state register and registered start pulse.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state_q <= RX_IDLE;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= confirm;
        end
    end

    assign sample_o = (state_q == RX_DATA) && zero_i;
    assign flush_o  = confirm;
    assign start_o  = start_q;

    AST_START_AFTER_CONFIRM: assert property (@(posedge clk) disable iff (!clr_n)
        start_o |-> ($past(state_q) == RX_CONFIRM)); // R4

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!clr_n)
        start_o |=> !start_o); // R4

    AST_SAMPLE_GAP: assert property (@(posedge clk) disable iff (!clr_n)
        sample_o |=> !sample_o); // R5

    AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
        (sample_o && stop_i) |=> (state_q == RX_IDLE)); // R8

endmodule

// File: rtl/rxs_window.sv
// Module: rxs_window
// What: shift window of received bits with a fill count. It compares the
//       updated window with the pattern and flags the all-ones end code.
// Assumes: flush_i and sample_i are never high in the same cycle.
module rxs_window #(
    parameter int PAT_W   = 4,
    localparam int FILL_W = $clog2(PAT_W + 1)
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             line_i,
    input  logic             sample_i,
    input  logic             flush_i,
    input  logic [PAT_W-1:0] pattern_i,
    output logic             stop_o,
    output logic             match_o
);

    logic [PAT_W-1:0]  win_q;
    logic [FILL_W-1:0] fill_q;
    logic [PAT_W-1:0]  win_nxt;
    logic              full_nxt;
    logic              hit_q;

    // Purpose: window contents and fill state after the pending sample.
    always_comb begin
        win_nxt  = {win_q[PAT_W-2:0], line_i};
        full_nxt = (fill_q >= FILL_W'(PAT_W - 1));
    end

    assign stop_o = full_nxt && (win_nxt == '1);

    // Purpose: shift in sampled bits, track fill, register the match pulse.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            win_q  <= '0;
            fill_q <= '0;
            hit_q  <= 1'b0;
        end else begin
            hit_q <= sample_i && full_nxt && (win_nxt == pattern_i);
            if (flush_i) begin
                win_q  <= '0;
                fill_q <= '0;
            end else if (sample_i) begin
                win_q <= win_nxt;
                if (fill_q != FILL_W'(PAT_W)) begin
                    fill_q <= fill_q + 1'b1;
                end
            end
        end
    end

    assign match_o = hit_q;

    AST_MATCH_NEEDS_FULL: assert property (@(posedge clk) disable iff (!clr_n)
        match_o |-> (fill_q == FILL_W'(PAT_W))); // R6

    AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!clr_n)
        match_o |=> !match_o); // R6

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!clr_n)
        flush_i |=> (fill_q == '0)); // R8

endmodule

// File: rtl/rxs_pattern_rx.sv
// Module: rxs_pattern_rx (top)
// What: oversampled serial receiver. It confirms start bits against noise,
//       samples each bit near its centre, matches a runtime 4-bit pattern
//       (overlaps included) and goes idle on an all-ones window.
// Assumes: clk runs at OSR times the bit rate; line_i is synchronised
//          outside this block; the idle line level is high.
module rxs_pattern_rx #(
    parameter int OSR         = 4,
    parameter int CONFIRM_DLY = 2,
    parameter int PAT_W       = 4,
    localparam int CNT_MAX    = (OSR > CONFIRM_DLY) ? OSR - 1 : CONFIRM_DLY - 1,
    localparam int CW         = (CNT_MAX < 1) ? 1 : $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             line_i,
    input  logic [PAT_W-1:0] pattern_i,
    output logic             start_o,
    output logic             match_o
);

    logic          ld;
    logic [CW-1:0] ld_val;
    logic          zero;
    logic          sample;
    logic          flush;
    logic          stop;

    rxs_phase_ctr #(.OSR(OSR), .CONFIRM_DLY(CONFIRM_DLY)) u_ctr (
        .clk        (clk),
        .clr_n      (clr_n),
        .load_i     (ld),
        .load_val_i (ld_val),
        .zero_o     (zero)
    );

    rxs_ctrl #(.OSR(OSR), .CONFIRM_DLY(CONFIRM_DLY)) u_ctrl (
        .clk        (clk),
        .clr_n      (clr_n),
        .line_i     (line_i),
        .zero_i     (zero),
        .stop_i     (stop),
        .load_o     (ld),
        .load_val_o (ld_val),
        .sample_o   (sample),
        .flush_o    (flush),
        .start_o    (start_o)
    );

    rxs_window #(.PAT_W(PAT_W)) u_win (
        .clk       (clk),
        .clr_n     (clr_n),
        .line_i    (line_i),
        .sample_i  (sample),
        .flush_i   (flush),
        .pattern_i (pattern_i),
        .stop_o    (stop),
        .match_o   (match_o)
    );

    AST_NO_SIMULTANEOUS: assert property (@(posedge clk) disable iff (!clr_n)
        !(start_o && match_o)); // R6

endmodule

// File: tb/sim_rxs_pattern_rx.sv
// Bench: behavioural reference model stepped on every clock and compared
// with the outputs at each falling edge, plus directed pulse counts.
module sim_rxs_pattern_rx;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       line = 1'b1;
    logic [3:0] pat = 4'b0110;
    logic       start_w, match_w;

    int n_chk = 0;
    int n_bad = 0;
    int tot_s = 0;
    int tot_z = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rxs_pattern_rx u0 (
        .clk       (clk),
        .clr_n     (clr_n),
        .line_i    (line),
        .pattern_i (pat),
        .start_o   (start_w),
        .match_o   (match_w)
    );

    // reference model state
    int   mode;     // 0 idle, 1 confirming, 2 receiving
    int   wait_n;
    bit   q[$];
    logic exp_s, exp_z;

    always @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            mode = 0; wait_n = 0; q.delete(); exp_s = 0; exp_z = 0;
        end else begin
            exp_s = 0; exp_z = 0;
            case (mode)
                0: if (line == 1'b0) begin mode = 1; wait_n = 2; end
                1: begin
                    wait_n--;
                    if (wait_n == 0) begin
                        if (line == 1'b0) begin
                            mode = 2; wait_n = 4; exp_s = 1; q.delete();
                        end else mode = 0;
                    end
                end
                default: begin
                    wait_n--;
                    if (wait_n == 0) begin
                        wait_n = 4;
                        q.push_back(line);
                        if (q.size() > 4) void'(q.pop_front());
                        if (q.size() == 4) begin
                            if ({q[0], q[1], q[2], q[3]} == pat) exp_z = 1;
                            if ({q[0], q[1], q[2], q[3]} == 4'b1111) mode = 0;
                        end
                    end
                end
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        check(start_w === exp_s, "R4 start pulse vs model", start_w, exp_s);
        check(match_w === exp_z, "R5 R6 match pulse vs model", match_w, exp_z);
        if (start_w === 1'b1) tot_s++;
        if (match_w === 1'b1) tot_z++;
    end

    task automatic hold(input logic b, input int n);
        line = b;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) hold(bits[i], 4);
    endtask

    task automatic expect_counts(input int s0, input int z0, input int ds, input int dz,
                                 input string tag);
        check(tot_s - s0 == ds, {tag, " start count"}, tot_s - s0, ds);
        check(tot_z - z0 == dz, {tag, " match count"}, tot_z - z0, dz);
    endtask

    initial begin
        int s0, z0;
        repeat (3) @(negedge clk);
        check(start_w == 1'b0 && match_w == 1'b0, "R1 outputs low in clear", {start_w, match_w}, 0);
        clr_n = 1'b1;
        @(negedge clk);

        // R2: idle line
        s0 = tot_s; z0 = tot_z;
        hold(1'b1, 40);
        expect_counts(s0, z0, 0, 0, "R2 idle");

        // R3: glitches of one and two cycles
        s0 = tot_s; z0 = tot_z;
        hold(1'b0, 1); hold(1'b1, 12);
        hold(1'b0, 2); hold(1'b1, 12);
        expect_counts(s0, z0, 0, 0, "R3 glitch");

        // R7: overlapping matches, then end code
        pat = 4'b0110;
        s0 = tot_s; z0 = tot_z;
        hold(1'b0, 4); send(16'b0110110110, 10); send(16'b1111, 4); hold(1'b1, 16);
        expect_counts(s0, z0, 1, 3, "R7 overlap");

        // R8: stale window must not match in a new stream
        pat = 4'b1110;
        s0 = tot_s; z0 = tot_z;
        hold(1'b0, 4); send(16'b1111, 4); hold(1'b1, 8);
        hold(1'b0, 4); send(16'b0001111, 7); hold(1'b1, 16);
        expect_counts(s0, z0, 2, 0, "R8 restart");

        // R9: pattern equal to end code
        pat = 4'b1111;
        s0 = tot_s; z0 = tot_z;
        hold(1'b0, 4); send(16'b1111, 4); hold(1'b1, 32);
        expect_counts(s0, z0, 1, 1, "R9 end match");

        // R10: pattern changed mid-stream
        pat = 4'b0110;
        s0 = tot_s; z0 = tot_z;
        hold(1'b0, 4); send(16'b0110, 4);
        pat = 4'b1001;
        send(16'b011111, 6); hold(1'b1, 16);
        expect_counts(s0, z0, 1, 2, "R10 runtime pattern");

        // R1: clear in the middle of a stream
        pat = 4'b0110;
        s0 = tot_s; z0 = tot_z;
        hold(1'b0, 4); hold(1'b0, 4); hold(1'b1, 2);
        #5 clr_n = 1'b0;
        #1 check(start_w == 1'b0 && match_w == 1'b0, "R1 async clear", {start_w, match_w}, 0);
        @(negedge clk);
        #5 clr_n = 1'b1;
        @(negedge clk);
        hold(1'b1, 12);
        hold(1'b0, 4); send(16'b0110, 4); send(16'b1111, 4); hold(1'b1, 16);
        expect_counts(s0, z0, 2, 1, "R1 after clear");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule